// File: doc/BRIEF.md
# Reed-Solomon Page Parity Engine

This block computes Reed-Solomon parity for one flash page sector of 512 bytes, taking one byte per strobe. Each byte is bit-inverted and widened to a 10-bit symbol. The symbol then goes into a six-stage encoder over GF(2^10). Because of the inversion, an erased page (all 0xFF) produces parity that reads back as all ones. The six parity symbols are packed into eight bytes. Software can read these bytes in two forms: an inverted form, and a non-inverted form with each byte's bits reversed.

A host starts an operation by writing a control byte. In generate mode the engine consumes 512 data bytes and then ignores any further strobes. In check mode the host streams the 512 data bytes and then the eight stored parity bytes. The engine compares the stored parity with the computed parity and sets a sticky error flag if they differ. The computed parity stays readable so that software can correct the data. Error location and correction are not part of this block.

Top module: `rsp_ecc_top`

## Requirements
- R1: The parity symbols p5..p0 are the remainder of x^6·m(x) divided by g(x) = (x+α^0)(x+α^1)…(x+α^5). The arithmetic is over GF(2^10) with field polynomial x^10+x^3+1, and α = 2. Each coefficient of m(x) is the bitwise inverse of a data byte, zero-extended to 10 bits. The first byte is the highest-degree coefficient. p_k is the coefficient of x^k.
- R2: A page of 512 bytes of 0xFF makes all eight bytes of the inverted bank read 0xFF.
- R3: Inverted bank: form a 64-bit word with bits [10·(5−k)+9 : 10·(5−k)] = ~p_k and bits [63:60] = 1111. `rd_sel` = j puts word bits [8j+7:8j] on `inv_byte`.
- R4: Raw bank: form the same 64-bit word with non-inverted p_k and bits [63:60] = 0000. `raw_byte` is byte j of that word with its bit order reversed (bit b of the output is bit 7−b of the byte).
- R5: A control write (`ctl_we`) with bit 7 set clears the encoder, the byte count, the error flag, the done flag and the stored-parity capture. Bit 6 selects generate mode (set) or check mode (clear). Bit 5 enables byte capture. 0xE0 starts generate mode and 0xA0 starts check mode.
- R6: After a control write of 0x00, strobes are ignored and the readout banks hold their values.
- R7: In generate mode, `done` rises one clock after the 512th accepted byte. Later strobes leave the parity and `done` unchanged.
- R8: In check mode, the 8 bytes after the data are taken as stored parity in inverted-bank byte order (j = 0..7). Their 60 parity bits are compared with the computed ones, and the 4 spare bits are ignored. On a mismatch, `err_flag` is set one clock after the 8th parity byte. `done` rises at the same edge.
- R9: `err_flag` stays set through further strobes and non-clearing control writes until a write with bit 7 set. A matching check leaves it low.
- R10: After reset the engine does not capture bytes, `err_flag` and `done` are low, and the inverted bank reads 0xFF in every byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_we | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte: bit 7 clear, bit 6 generate, bit 5 enable |
| dat_stb | input | 1 | Data or stored-parity byte strobe |
| dat_byte | input | 8 | Byte accompanying `dat_stb` |
| rd_sel | input | 3 | Parity byte index for readout |
| inv_byte | output | 8 | Selected byte of the inverted bank |
| raw_byte | output | 8 | Selected byte of the bit-reversed raw bank |
| err_flag | output | 1 | Sticky parity mismatch flag |
| done | output | 1 | Required byte count consumed |

## Verification
Every accepted byte or control write updates state at the rising edge where it is sampled. The parity banks, `done` and `err_flag` therefore reflect that byte exactly one clock later, and the readout mux adds no register stage. The bench drives each stimulus on a falling edge and reads results at the following falling edge, after the single update edge. It steps `rd_sel` between reads, still away from the rising edge. Expected parity comes from the bench's own long division using log/antilog tables, not from the encoder's structure.

// File: rtl/rsp_pkg.sv
// Shared constants and GF(2^10) helpers for the page parity engine.
// Assumes a monic generator whose roots are consecutive powers of alpha = 2.
package rsp_pkg;
    localparam int SYM_W       = 10;
    localparam int NPAR        = 6;
    localparam int DATA_BYTES  = 512;
    localparam int BYTE_W      = 8;
    localparam logic [SYM_W:0] FIELD_POLY = 11'h409;
    localparam int PAR_BITS    = NPAR * SYM_W;
    localparam int PAR_BYTES   = (PAR_BITS + BYTE_W - 1) / BYTE_W;
    localparam int WORD_BITS   = PAR_BYTES * BYTE_W;
    localparam int TOTAL_BYTES = DATA_BYTES + PAR_BYTES;
    localparam int CNT_W       = $clog2(TOTAL_BYTES + 1);
    localparam int SEL_W       = $clog2(PAR_BYTES);
    localparam int CTL_CLR     = 7;
    localparam int CTL_GEN     = 6;
    localparam int CTL_ENA     = 5;

    typedef logic [SYM_W-1:0] sym_t;

    // Carry-less product reduced by the field polynomial.
    function automatic sym_t gf_mul(sym_t a, sym_t b);
        sym_t acc = '0;
        sym_t sh  = a;
        for (int i = 0; i < SYM_W; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = {sh[SYM_W-2:0], 1'b0} ^ (sh[SYM_W-1] ? FIELD_POLY[SYM_W-1:0] : '0);
        end
        return acc;
    endfunction

    // Coefficient k of the generator product over roots alpha^0..alpha^(NPAR-1).
    function automatic sym_t gen_coef(int k);
        sym_t g [NPAR+1];
        sym_t root = sym_t'(1);
        for (int j = 0; j <= NPAR; j++) g[j] = '0;
        g[0] = sym_t'(1);
        for (int i = 0; i < NPAR; i++) begin
            for (int j = NPAR; j >= 1; j--) g[j] = g[j-1] ^ gf_mul(g[j], root);
            g[0] = gf_mul(g[0], root);
            root = gf_mul(root, sym_t'(2));
        end
        return g[k];
    endfunction
endpackage

// File: rtl/rsp_lfsr.sv
// Six-stage symbol-serial division register: one symbol per shift_en.
// Assumes clr has priority over shift_en; holds otherwise.
module rsp_lfsr
    import rsp_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                shift_en,
    input  sym_t                sym_in,
    output logic [PAR_BITS-1:0] par
);
    logic [PAR_BITS-1:0] st;
    logic [PAR_BITS-1:0] nxt;
    sym_t                fb;

    // Feedback taken from the highest-degree stage.
    assign fb = sym_in ^ st[(NPAR-1)*SYM_W +: SYM_W];

    // Per-stage next value: previous stage plus feedback times its coefficient.
    for (genvar k = 0; k < NPAR; k++) begin : g_stage
        localparam sym_t GK = gen_coef(k);
        if (k == 0) begin : g_first
            assign nxt[0 +: SYM_W] = gf_mul(fb, GK);
        end else begin : g_rest
            assign nxt[k*SYM_W +: SYM_W] = st[(k-1)*SYM_W +: SYM_W] ^ gf_mul(fb, GK);
        end
    end

    // Stage registers: clear, shift or hold.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) st <= '0;
        else if (shift_en) st <= nxt;
    end

    assign par = st;

    // R6: without a shift or clear the remainder must not move.
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_en && !clr) |=> $stable(par));
endmodule

// File: rtl/rsp_pack.sv
// Packs parity symbols into the inverted and bit-reversed raw byte banks.
// Assumes symbol NPAR-1 occupies the lowest bits; spare bits filled per bank.
module rsp_pack
    import rsp_pkg::*;
(
    input  logic [PAR_BITS-1:0]  par,
    input  logic [SEL_W-1:0]     rd_sel,
    output logic [WORD_BITS-1:0] inv_word,
    output logic [BYTE_W-1:0]    inv_byte,
    output logic [BYTE_W-1:0]    raw_byte
);
    logic [WORD_BITS-1:0] raw_word;
    logic [WORD_BITS-1:0] rev_word;

    // Symbol placement: highest-degree symbol first, LSB-first.
    for (genvar k = 0; k < NPAR; k++) begin : g_place
        assign raw_word[(NPAR-1-k)*SYM_W +: SYM_W] = par[k*SYM_W +: SYM_W];
        assign inv_word[(NPAR-1-k)*SYM_W +: SYM_W] = ~par[k*SYM_W +: SYM_W];
    end

    // Spare bits: ones in the inverted bank, zeros in the raw bank.
    if (WORD_BITS > PAR_BITS) begin : g_spare
        assign raw_word[WORD_BITS-1:PAR_BITS] = '0;
        assign inv_word[WORD_BITS-1:PAR_BITS] = '1;
    end

    // Per-byte bit reversal of the raw bank.
    for (genvar j = 0; j < PAR_BYTES; j++) begin : g_byte
        for (genvar b = 0; b < BYTE_W; b++) begin : g_bit
            assign rev_word[j*BYTE_W + b] = raw_word[j*BYTE_W + BYTE_W-1-b];
        end
    end

    // Readout byte selection.
    always_comb begin
        inv_byte = inv_word[rd_sel*BYTE_W +: BYTE_W];
        raw_byte = rev_word[rd_sel*BYTE_W +: BYTE_W];
    end
endmodule

// File: rtl/rsp_seq.sv
// Control decode, byte counting, stored-parity capture and mismatch flag.
// Assumes a control write in the same cycle as a strobe wins over the strobe.
module rsp_seq
    import rsp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ctl_we,
    input  logic [BYTE_W-1:0]    ctl_wdata,
    input  logic                 dat_stb,
    input  logic [BYTE_W-1:0]    dat_byte,
    input  logic [WORD_BITS-1:0] inv_word,
    output logic                 clr,
    output logic                 shift_en,
    output sym_t                 sym,
    output logic                 err_flag,
    output logic                 done
);
    logic [CNT_W-1:0]     cnt;
    logic [CNT_W-1:0]     limit;
    logic [CNT_W-1:0]     off;
    logic [SEL_W-1:0]     pidx;
    logic [WORD_BITS-1:0] stash;
    logic [WORD_BITS-1:0] cand;
    logic                 run_en, gen_mode, err_q, done_q;
    logic                 accept, in_data, last, mismatch;

    // Decode of the current strobe against mode and count.
    always_comb begin
        clr      = ctl_we & ctl_wdata[CTL_CLR];
        limit    = gen_mode ? CNT_W'(DATA_BYTES) : CNT_W'(TOTAL_BYTES);
        accept   = dat_stb & run_en & ~ctl_we & (cnt < limit);
        in_data  = cnt < CNT_W'(DATA_BYTES);
        last     = (cnt == limit - CNT_W'(1));
        shift_en = accept & in_data;
        sym      = {{(SYM_W-BYTE_W){1'b0}}, ~dat_byte};
        off      = cnt - CNT_W'(DATA_BYTES);
        pidx     = off[SEL_W-1:0];
    end

    // Stored parity with the incoming byte merged at its slot.
    always_comb begin
        cand = stash;
        cand[pidx*BYTE_W +: BYTE_W] = dat_byte;
        mismatch = cand[PAR_BITS-1:0] != inv_word[PAR_BITS-1:0];
    end

    // Mode, count, capture and flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_en <= 1'b0; gen_mode <= 1'b0; cnt <= '0;
            err_q <= 1'b0; done_q <= 1'b0; stash <= '0;
        end else if (ctl_we) begin
            run_en   <= ctl_wdata[CTL_ENA];
            gen_mode <= ctl_wdata[CTL_GEN];
            if (clr) begin
                cnt <= '0; err_q <= 1'b0; done_q <= 1'b0; stash <= '0;
            end
        end else if (accept) begin
            cnt <= cnt + CNT_W'(1);
            if (last) done_q <= 1'b1;
            if (!in_data) stash <= cand;
            if (!in_data && last && mismatch) err_q <= 1'b1;
        end
    end

    assign err_flag = err_q;
    assign done     = done_q;

    // R5: a clearing write empties count and flags.
    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0 && !err_flag && !done));
    // R9: the error flag only drops on a clearing write.
    p_err_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !clr) |=> err_flag);
    // R7: once generate mode is complete the count stays put.
    p_no_overrun_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && gen_mode && !ctl_we) |=> $stable(cnt));
    // R8: the count never passes the page plus parity length.
    p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(TOTAL_BYTES));
    // R8: an error only appears together with completion.
    p_err_at_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flag) |-> done);
endmodule

// File: rtl/rsp_ecc_top.sv
// Top of the page parity engine: sequencer, encoder and readout packing.
// Assumes one byte per strobe and a byte-wide control write port.
module rsp_ecc_top
    import rsp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic [7:0]       ctl_wdata,
    input  logic             dat_stb,
    input  logic [7:0]       dat_byte,
    input  logic [2:0]       rd_sel,
    output logic [7:0]       inv_byte,
    output logic [7:0]       raw_byte,
    output logic             err_flag,
    output logic             done
);
    logic                 clr, shift_en;
    sym_t                 sym;
    logic [PAR_BITS-1:0]  par;
    logic [WORD_BITS-1:0] inv_word;

    rsp_seq u_seq (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .dat_stb(dat_stb), .dat_byte(dat_byte), .inv_word(inv_word),
        .clr(clr), .shift_en(shift_en), .sym(sym),
        .err_flag(err_flag), .done(done)
    );

    rsp_lfsr u_lfsr (
        .clk(clk), .rst_n(rst_n), .clr(clr), .shift_en(shift_en),
        .sym_in(sym), .par(par)
    );

    rsp_pack u_pack (
        .par(par), .rd_sel(rd_sel), .inv_word(inv_word),
        .inv_byte(inv_byte), .raw_byte(raw_byte)
    );
endmodule

// File: tb/sim_rsp_ecc_top.sv
`timescale 1ns/1ps
module sim_rsp_ecc_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_we = 1'b0;
    logic [7:0] ctl_wdata = 8'h00;
    logic       dat_stb = 1'b0;
    logic [7:0] dat_byte = 8'h00;
    logic [2:0] rd_sel = 3'd0;
    logic [7:0] inv_byte, raw_byte;
    logic       err_flag, done;

    int nchk = 0;
    int nfail = 0;

    always #4 clk = ~clk;

    rsp_ecc_top u0 (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .dat_stb(dat_stb), .dat_byte(dat_byte), .rd_sel(rd_sel),
        .inv_byte(inv_byte), .raw_byte(raw_byte),
        .err_flag(err_flag), .done(done)
    );

    // Vector: [15:14] pattern, [13] corrupt, [12:10] corrupt byte, [7:0] seed.
    localparam logic [15:0] VEC [6] = '{
        16'hC000,  // all 0xFF page (R2)
        16'h2C00,  // all 0x00, corrupt byte 3
        16'h4011,  // ramp
        16'hBC5A,  // mix, corrupt byte 7
        16'h60C3,  // ramp, corrupt byte 0
        16'h8007   // mix
    };

    logic [9:0] lg_exp [0:1022];
    int         lg_log [0:1023];
    logic [9:0] gd [0:6];
    logic [9:0] arr [0:527];
    logic [9:0] ep [0:5];
    logic [63:0] exp_inv, exp_rev;

    function automatic logic [9:0] gm(logic [9:0] a, logic [9:0] b);
        if (a == 0 || b == 0) return 10'd0;
        return lg_exp[(lg_log[a] + lg_log[b]) % 1023];
    endfunction

    function automatic logic [7:0] pat(int kind, int seed, int i);
        case (kind)
            0: return 8'(seed);
            1: return 8'(i + seed);
            2: return 8'((i * seed) ^ (i >> 3));
            default: return 8'hFF;
        endcase
    endfunction

    task automatic build_field();
        logic [10:0] v = 11'd1;
        for (int i = 0; i < 1023; i++) begin
            lg_exp[i] = v[9:0];
            lg_log[v[9:0]] = i;
            v = {v[9:0], 1'b0};
            if (v[10]) v = v ^ 11'h409;
        end
        gd[0] = 10'd1;
        for (int j = 1; j <= 6; j++) gd[j] = 10'd0;
        for (int i = 0; i < 6; i++)
            for (int j = i + 1; j >= 1; j--) gd[j] = gd[j] ^ gm(lg_exp[i], gd[j-1]);
    endtask

    // Expected parity of the first n bytes of a pattern (R1, R3, R4).
    task automatic calc_exp(int kind, int seed, int n);
        logic [63:0] w = 64'd0;
        for (int i = 0; i < n + 6; i++) arr[i] = (i < n) ? {2'b00, ~pat(kind, seed, i)} : 10'd0;
        for (int i = 0; i < n; i++) begin
            logic [9:0] c = arr[i];
            for (int j = 1; j <= 6; j++) arr[i+j] = arr[i+j] ^ gm(c, gd[j]);
        end
        for (int k = 0; k < 6; k++) ep[k] = arr[n + 5 - k];
        for (int k = 0; k < 6; k++) w[10*(5-k) +: 10] = ep[k];
        exp_inv = {4'hF, ~w[59:0]};
        for (int j = 0; j < 8; j++)
            for (int b = 0; b < 8; b++) exp_rev[8*j + b] = w[8*j + 7 - b];
    endtask

    task automatic chk(string req, logic [63:0] act, logic [63:0] expv);
        nchk++;
        if (act !== expv) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic wr_ctl(logic [7:0] v);
        @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
        @(negedge clk); ctl_we = 1'b0;
    endtask

    task automatic send(logic [7:0] b);
        @(negedge clk); dat_stb = 1'b1; dat_byte = b;
        @(negedge clk); dat_stb = 1'b0;
    endtask

    task automatic send_page(int kind, int seed, int n);
        for (int i = 0; i < n; i++) send(pat(kind, seed, i));
    endtask

    task automatic send_stored(logic [63:0] s);
        for (int j = 0; j < 8; j++) send(s[8*j +: 8]);
    endtask

    task automatic chk_banks(string req, logic [63:0] ei, logic [63:0] er, logic do_raw);
        for (int j = 0; j < 8; j++) begin
            rd_sel = 3'(j); #1;
            chk(req, {56'd0, inv_byte}, {56'd0, ei[8*j +: 8]});
            if (do_raw) chk("R4", {56'd0, raw_byte}, {56'd0, er[8*j +: 8]});
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        logic [63:0] st;
        build_field();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: reset state, and strobes before any control write are ignored.
        chk("R10", {62'd0, err_flag, done}, 64'd0);
        chk_banks("R10", {64{1'b1}}, 64'd0, 1'b0);
        for (int i = 0; i < 4; i++) send(8'h5A);
        chk("R10", {63'd0, done}, 64'd0);
        chk_banks("R10", {64{1'b1}}, 64'd0, 1'b0);

        // Vector table walk: generate (R1-R4, R7) then check (R8, R9).
        foreach (VEC[v]) begin
            int kind = int'(VEC[v][15:14]);
            logic cor = VEC[v][13];
            int cidx = int'(VEC[v][12:10]);
            int seed = int'(VEC[v][7:0]);
            calc_exp(kind, seed, 512);
            wr_ctl(8'hE0);
            send_page(kind, seed, 512);
            chk("R7", {63'd0, done}, 64'd1);
            chk_banks(kind == 3 ? "R2" : "R1/R3", exp_inv, exp_rev, 1'b1);
            wr_ctl(8'hA0);
            chk("R5", {62'd0, err_flag, done}, 64'd0);
            send_page(kind, seed, 512);
            st = exp_inv;
            if (cor) st[8*cidx] = ~st[8*cidx];
            send_stored(st);
            chk("R8", {62'd0, err_flag, done}, {62'd0, cor, 1'b1});
        end

        // R6: freeze after 100 bytes; later strobes do nothing.
        calc_exp(1, 8'h11, 100);
        wr_ctl(8'hE0);
        send_page(1, 8'h11, 100);
        wr_ctl(8'h00);
        for (int i = 0; i < 20; i++) send(8'hA5);
        chk("R6", {63'd0, done}, 64'd0);
        chk_banks("R6", exp_inv, exp_rev, 1'b1);

        // R7: extra strobes after a full generate page are ignored.
        calc_exp(2, 8'h5A, 512);
        wr_ctl(8'hE0);
        send_page(2, 8'h5A, 512);
        for (int i = 0; i < 5; i++) send(8'h33);
        chk("R7", {63'd0, done}, 64'd1);
        chk_banks("R7", exp_inv, exp_rev, 1'b0);

        // R8: spare bits of stored parity are not compared.
        calc_exp(3, 0, 512);
        wr_ctl(8'hA0);
        send_page(3, 0, 512);
        st = exp_inv;
        st[63:60] = 4'h0;
        send_stored(st);
        chk("R8", {62'd0, err_flag, done}, 64'd1);

        // R9: mismatch flag survives strobes and a freeze, drops on clear.
        calc_exp(1, 8'h11, 512);
        wr_ctl(8'hA0);
        send_page(1, 8'h11, 512);
        st = exp_inv;
        st[16] = ~st[16];
        send_stored(st);
        chk("R9", {63'd0, err_flag}, 64'd1);
        for (int i = 0; i < 3; i++) send(8'h00);
        chk("R9", {63'd0, err_flag}, 64'd1);
        wr_ctl(8'h00);
        chk("R9", {63'd0, err_flag}, 64'd1);
        wr_ctl(8'hA0);
        chk("R9", {62'd0, err_flag, done}, 64'd0);
        chk_banks("R5", {64{1'b1}}, 64'd0, 1'b1);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule